// File: doc/BRIEF.md
# Level-Grouped Interrupt Status Controller

This block gathers thirteen peripheral interrupt request lines into one 32-bit status word at fixed, sparse bit positions, and combines that word with a 32-bit enable mask. From the enabled pending bits it produces a 3-bit priority level for the processor. Each line belongs to one of three priority groups: 3, 5 and 6.

A change on a request line is treated as an event. A rising line sets its status bit. A falling line clears it. Between events, software may overwrite the status word and the mask over a simple word-wide register bus. Reads are combinational. Writes take effect at the next clock edge.

The level output is registered. It names the highest group that has at least one bit that is both pending and enabled. It is zero when no such bit exists. Software bits that lie outside every group are stored and read back, but they never raise the level.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset, the status word, the mask word and the level output are all zero.
- R2: When a request line goes high, its status bit is set at that clock edge. The line-to-bit map (line index:bit) is 0:7, 1:3, 2:2, 3:9, 4:10, 5:12, 6:5, 7:17, 8:28, 9:27, 10:26, 11:23, 12:21.
- R3: When a request line goes low, its status bit is cleared at that clock edge.
- R4: A bus write to word offset 0x7000 replaces all 32 status bits, and a read of 0x7000 returns the status word.
- R5: A bus write to word offset 0x7800 replaces the mask word, and a read of 0x7800 returns it. A mask bit of 1 enables the matching status bit.
- R6: When a request line changes in the same cycle as a status write, the line's own bit takes the line's new value. Every other bit takes the written data.
- R7: One cycle after status or mask changes, the level output follows this rule. It is 6 if any of bits 21, 23, 26, 27, 28 is pending and enabled. Otherwise it is 5 if bit 17 is pending and enabled. Otherwise it is 3 if any of bits 2, 3, 5, 7, 9, 10, 12 is pending and enabled. Otherwise it is 0.
- R8: Status bits outside the three groups never affect the level. Reads of any offset other than 0x7000 and 0x7800 return zero, and writes to them change nothing.
- R9: A request line held steady does not re-set its bit after software clears it. Only a new change on the line acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 13 | Peripheral request lines, indexed as in R2 |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 16 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the addressed register |
| cpu_level_o | output | 3 | Registered priority level: 0, 3, 5 or 6 |

## Verification
A request-line change and a software write to the status word can reach the same status bit in the same clock edge.

The bench provokes this collision by driving a line edge and a status write on the same falling clock phase. It does this once for a rising line and once for a falling line, each time with write data that holds the opposite value on that line's bit. It then reads the word back and expects the line's value on its own bit and the written data on all other bits.

A separate case holds a line steady while software clears its bit. This shows that the collision rule applies only on a change of the line, not on its level.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  parameter int NUM_SRC = 13;
  parameter int DATA_W  = 32;

  typedef logic [2:0] lvl_t;

  // Fixed placement of each request line in the status word.
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 7;
      1:       return 3;
      2:       return 2;
      3:       return 9;
      4:       return 10;
      5:       return 12;
      6:       return 5;
      7:       return 17;
      8:       return 28;
      9:       return 27;
      10:      return 26;
      11:      return 23;
      default: return 21;
    endcase
  endfunction

  // Priority group of each request line.
  function automatic lvl_t src_lvl(input int idx);
    if (idx <= 6)      return 3'd3;
    else if (idx == 7) return 3'd5;
    else               return 3'd6;
  endfunction

  // Status bits that belong to one priority group.
  function automatic logic [DATA_W-1:0] group_bits(input lvl_t lvl);
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (src_lvl(i) == lvl) acc[src_bit(i)] = 1'b1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/irq_src_edge.sv
module irq_src_edge #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] src_q;
  logic [N-1:0] src_d;

  always_comb src_d = src_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= src_d;
  end

  assign evt_o = src_i ^ src_q;
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import irq_agg_pkg::*;
#(
  parameter int          N          = NUM_SRC,
  parameter int          W          = DATA_W,
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] STATUS_OFS = 16'h7000,
  parameter logic [15:0] MASK_OFS   = 16'h7800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [N-1:0]      evt_i,
  input  logic [N-1:0]      src_i,
  output logic [W-1:0]      status_o,
  output logic [W-1:0]      mask_o
);
  logic [W-1:0] status_q, status_d;
  logic [W-1:0] mask_q, mask_d;
  logic         hit_status, hit_mask;
  logic         status_en, mask_en;

  assign hit_status = wr_i && (addr_i == ADDR_W'(STATUS_OFS));
  assign hit_mask   = wr_i && (addr_i == ADDR_W'(MASK_OFS));
  assign status_en  = hit_status || (|evt_i);
  assign mask_en    = hit_mask;

  always_comb begin
    status_d = hit_status ? wdata_i : status_q;
    // A line change overrides the written data for its own bit.
    for (int i = 0; i < N; i++) begin
      if (evt_i[i]) status_d[src_bit(i)] = src_i[i];
    end
    mask_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/irq_level_enc.sv
module irq_level_enc
  import irq_agg_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output lvl_t         level_o
);
  localparam logic [W-1:0] G3 = group_bits(3'd3);
  localparam logic [W-1:0] G5 = group_bits(3'd5);
  localparam logic [W-1:0] G6 = group_bits(3'd6);

  logic [W-1:0] pend;
  lvl_t         level_d, level_q;

  assign pend = status_i & mask_i;

  always_comb begin
    if      (|(pend & G6)) level_d = 3'd6;
    else if (|(pend & G5)) level_d = 3'd5;
    else if (|(pend & G3)) level_d = 3'd3;
    else                   level_d = 3'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 3'd0;
    else        level_q <= level_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_agg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] STATUS_OFS = 16'h7000,
  parameter logic [15:0] MASK_OFS   = 16'h7800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [2:0]         cpu_level_o
);
  logic [NUM_SRC-1:0] evt;
  logic [DATA_W-1:0]  status_q;
  logic [DATA_W-1:0]  mask_q;
  lvl_t               level;

  irq_src_edge #(.N(NUM_SRC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (src_i),
    .evt_o (evt)
  );

  irq_status_regs #(
    .N(NUM_SRC), .W(DATA_W), .ADDR_W(ADDR_W),
    .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .evt_i    (evt),
    .src_i    (src_i),
    .status_o (status_q),
    .mask_o   (mask_q)
  );

  irq_level_enc #(.W(DATA_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_q),
    .mask_i   (mask_q),
    .level_o  (level)
  );

  always_comb begin
    if (bus_addr_i == ADDR_W'(STATUS_OFS))    bus_rdata_o = status_q;
    else if (bus_addr_i == ADDR_W'(MASK_OFS)) bus_rdata_o = mask_q;
    else                                      bus_rdata_o = '0;
  end

  assign cpu_level_o = level;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk
  import irq_agg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] STATUS_OFS = 16'h7000,
  parameter logic [15:0] MASK_OFS   = 16'h7800
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_i,
  input logic               bus_wr_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic [DATA_W-1:0]  status_q,
  input logic [DATA_W-1:0]  mask_q,
  input logic [2:0]         cpu_level_o
);
  logic [NUM_SRC-1:0] prev_src;
  logic               any_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_src <= '0;
    else        prev_src <= src_i;
  end

  assign any_evt = |(src_i ^ prev_src);

  function automatic logic [2:0] want_level(input logic [DATA_W-1:0] p);
    if      (|(p & group_bits(3'd6))) return 3'd6;
    else if (|(p & group_bits(3'd5))) return 3'd5;
    else if (|(p & group_bits(3'd3))) return 3'd3;
    else                              return 3'd0;
  endfunction

  // R2 and R3: every line change lands on its mapped bit (R6: even when a write collides)
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
    localparam int B = src_bit(k);
    a_r2_src_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[k] != prev_src[k]) |=> (status_q[B] == $past(src_i[k])));
  end

  a_r4_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(STATUS_OFS) && !any_evt)
      |=> (status_q == $past(bus_wdata_i)));

  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i == ADDR_W'(MASK_OFS)) |=> (mask_q == $past(bus_wdata_i)));

  a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_evt && !(bus_wr_i && bus_addr_i == ADDR_W'(STATUS_OFS))) |=> $stable(status_q));

  a_r7_level_rule: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_level_o == want_level($past(status_q & mask_q))));

  a_r7_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level_o == 3'd0 || cpu_level_o == 3'd3 || cpu_level_o == 3'd5 || cpu_level_o == 3'd6));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(
  .ADDR_W(ADDR_W), .STATUS_OFS(STATUS_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_i       (src_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .cpu_level_o (cpu_level_o)
);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] src = '0;
  logic        wr = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [2:0]  level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int bmap [13] = '{7, 3, 2, 9, 10, 12, 5, 17, 28, 27, 26, 23, 21};
  int blvl [13] = '{3, 3, 3, 3, 3, 3, 3, 5, 6, 6, 6, 6, 6};

  localparam logic [15:0] ST = 16'h7000;
  localparam logic [15:0] MK = 16'h7800;

  always #10 clk = ~clk;

  irq_level_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .cpu_level_o (level)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog got=%0d exp=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] spat, mpat;
    int pend, expl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    bus_read(ST, v); chk("R1 status", v, 32'h0);
    bus_read(MK, v); chk("R1 mask", v, 32'h0);
    chk("R1 level", {29'h0, level}, 32'h0);

    // R5: mask write and read back
    bus_write(MK, 32'hFFFF_FFFF);
    bus_read(MK, v); chk("R5 mask", v, 32'hFFFF_FFFF);

    // R2, R3, R7: sweep every request line
    for (int i = 0; i < 13; i++) begin
      src[i] = 1'b1;
      @(negedge clk);
      bus_read(ST, v); chk($sformatf("R2 src%0d", i), v, 32'h1 << bmap[i]);
      @(negedge clk);
      chk($sformatf("R7 src%0d level", i), {29'h0, level}, blvl[i]);
      src[i] = 1'b0;
      @(negedge clk);
      bus_read(ST, v); chk($sformatf("R3 src%0d", i), v, 32'h0);
      @(negedge clk);
      chk($sformatf("R3 src%0d level", i), {29'h0, level}, 32'h0);
    end

    // R4: whole status replace
    bus_write(ST, 32'hA5A5_5A5A);
    bus_read(ST, v); chk("R4 status", v, 32'hA5A5_5A5A);
    bus_write(ST, 32'h0);
    bus_read(ST, v); chk("R4 clear", v, 32'h0);

    // R6: line edge collides with a status write
    src[0] = 1'b1;
    bus_write(ST, 32'hFFFF_0000);
    bus_read(ST, v); chk("R6 rise wins", v, 32'hFFFF_0080);
    src[0] = 1'b0;
    bus_write(ST, 32'hFFFF_FFFF);
    bus_read(ST, v); chk("R6 fall wins", v, 32'hFFFF_FF7F);

    // R9: steady line does not re-set a cleared bit
    bus_write(ST, 32'h0);
    src[5] = 1'b1;
    @(negedge clk);
    bus_read(ST, v); chk("R9 set", v, 32'h0000_1000);
    bus_write(ST, 32'h0);
    repeat (3) @(negedge clk);
    bus_read(ST, v); chk("R9 stays clear", v, 32'h0);
    chk("R9 level", {29'h0, level}, 32'h0);
    src[5] = 1'b0;
    @(negedge clk);

    // R8: unmapped offsets
    bus_write(16'h7004, 32'hDEAD_BEEF);
    bus_read(16'h7004, v); chk("R8 unmapped read", v, 32'h0);
    bus_read(ST, v); chk("R8 status untouched", v, 32'h0);
    bus_read(MK, v); chk("R8 mask untouched", v, 32'hFFFF_FFFF);

    // R7, R8: every group/enable combination, with group-free bits always set
    for (int g = 0; g < 8; g++) begin
      for (int m = 0; m < 8; m++) begin
        spat = 32'h8000_0003 | ((g & 1) ? 32'h4 : 0) | ((g & 2) ? 32'h2_0000 : 0)
                             | ((g & 4) ? 32'h20_0000 : 0);
        mpat = 32'h8000_0003 | ((m & 1) ? 32'h4 : 0) | ((m & 2) ? 32'h2_0000 : 0)
                             | ((m & 4) ? 32'h20_0000 : 0);
        bus_write(ST, spat);
        bus_write(MK, mpat);
        @(negedge clk);
        pend = g & m;
        expl = (pend & 4) ? 6 : (pend & 2) ? 5 : (pend & 1) ? 3 : 0;
        chk($sformatf("R7 g%0d m%0d", g, m), {29'h0, level}, expl);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule